// File: doc/BRIEF.md
# Lane-Splittable 16-bit Array Multiplier

This block multiplies a 16-bit two's-complement multiplicand by a 16-bit unsigned multiplier. A single mode input selects how the one array is used. In joined mode it produces one full 32-bit product. In split mode the same array produces two independent 8-bit products. Each of these takes a signed byte of the multiplicand and an unsigned byte of the multiplier, and the two 16-bit results are packed side by side in the output word.

The array has three stages:
- A preconditioning stage builds one multiplicand image for the low lane and one for the high lane.
- Eight partial-product units each combine two adjacent multiplier bits with the multiplicand and add the two shifted rows. Their internal carry is gated off at the lane boundary in split mode.
- Three levels of pairwise addition fold the eight unit outputs into one word. The first level is lane-partitionable, and the two later levels are plain fixed-width adders.

An optional output register selects between a purely combinational result and a result with one cycle of latency. The mode and both operands may change on every cycle, so an image datapath can interleave wide and narrow work without idle cycles.

Top module: `smul_array16`

## Requirements
- R1: With `split_i` = 0, `prod_o` equals the 32-bit two's-complement value of signed(`mcand_i`) times unsigned(`mplier_i`). The result is exact over the full operand range, including -32768 times 65535.
- R2: With `split_i` = 1, `prod_o[15:0]` equals the 16-bit two's-complement value of signed(`mcand_i[7:0]`) times unsigned(`mplier_i[7:0]`).
- R3: With `split_i` = 1, `prod_o[31:16]` equals the 16-bit two's-complement value of signed(`mcand_i[15:8]`) times unsigned(`mplier_i[15:8]`).
- R4: With `split_i` = 1, no carry or sign bit crosses between bit 15 and bit 16. The low half depends only on the low operand bytes, and the high half depends only on the high operand bytes.
- R5: With `OUT_REG` = 1, the result for the inputs sampled at a rising clock edge appears on `prod_o` after that edge. A new operand pair and mode are accepted on every cycle, back to back.
- R6: While `rst_n` is low, `prod_o` is zero. Reset takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset; asserts asynchronously |
| split_i | input | 1 | 0: one 16x16 product; 1: two 8x8 lane products |
| mcand_i | input | 16 | Multiplicand, two's complement (per byte in split mode) |
| mplier_i | input | 16 | Multiplier, unsigned (per byte in split mode) |
| prod_o | output | 32 | Product; in split mode {high lane, low lane} |

## Verification
The bench builds the block with its defaults: `LANE_W` = 8 and `OUT_REG` = 1. This gives the 16-bit array and eight units in three adder levels, and it puts the registered output and asynchronous reset under test. With these values the extreme operands are reached in both modes: the most negative multiplicand with an all-ones multiplier, and sign bits set in one lane but not the other. Carry and sign spill at bit 16 are therefore exercised. Back-to-back vectors that alternate the mode cover the case where the output register holds a result from the other mode.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    LANES_JOINED = 1'b0,
    LANES_SPLIT  = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/smul_precond.sv
module smul_precond #(
  parameter int LANE_W = 8
) (
  input  logic                  split_i,
  input  logic [2*LANE_W-1:0]   mcand_i,
  output logic [2*LANE_W-1:0]   lo_path_o,
  output logic [2*LANE_W-1:0]   hi_path_o
);
  import smul_pkg::*;
  localparam int DW = 2 * LANE_W;

  lane_mode_e mode;
  assign mode = lane_mode_e'(split_i);

  always_comb begin
    if (mode == LANES_SPLIT) begin
      // low lane: byte sign-extended across the word
      lo_path_o = {{LANE_W{mcand_i[LANE_W-1]}}, mcand_i[LANE_W-1:0]};
      // high lane: low byte forced to zero
      hi_path_o = {mcand_i[DW-1:LANE_W], {LANE_W{1'b0}}};
    end else begin
      lo_path_o = mcand_i;
      hi_path_o = mcand_i;
    end
  end
endmodule

// File: rtl/smul_ppu.sv
module smul_ppu #(
  parameter int DW  = 16,
  parameter int IDX = 0
) (
  input  logic            split_i,
  input  logic [DW-1:0]   mc_i,
  input  logic [1:0]      mbits_i,
  output logic [2*DW-1:0] pp_o
);
  localparam int PW       = 2 * DW;
  localparam int SH0      = 2 * IDX;
  localparam bit LOW_UNIT = (IDX < DW / 4);

  logic [PW-1:0] ext, row0, row1, keep;
  logic [DW:0]   lo_sum;
  logic          hi_cin;
  logic [DW-1:0] hi_sum;

  always_comb begin
    ext  = {{DW{mc_i[DW-1]}}, mc_i};
    keep = (split_i && LOW_UNIT) ? {{DW{1'b0}}, {DW{1'b1}}} : {PW{1'b1}};
    row0 = ((ext & {PW{mbits_i[0]}}) << SH0) & keep;
    row1 = ((ext & {PW{mbits_i[1]}}) << (SH0 + 1)) & keep;
    lo_sum = {1'b0, row0[DW-1:0]} + {1'b0, row1[DW-1:0]};
    hi_cin = lo_sum[DW] & ~split_i;
    hi_sum = row0[PW-1:DW] + row1[PW-1:DW] + {{(DW-1){1'b0}}, hi_cin};
    pp_o   = {hi_sum, lo_sum[DW-1:0]};
  end
endmodule

// File: rtl/smul_padd.sv
module smul_padd #(
  parameter int DW = 16
) (
  input  logic            split_i,
  input  logic [2*DW-1:0] a_i,
  input  logic [2*DW-1:0] b_i,
  output logic [2*DW-1:0] sum_o
);
  localparam int PW = 2 * DW;

  logic [DW:0]   lo_sum;
  logic          hi_cin;
  logic [DW-1:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, a_i[DW-1:0]} + {1'b0, b_i[DW-1:0]};
    hi_cin = lo_sum[DW] & ~split_i;
    hi_sum = a_i[PW-1:DW] + b_i[PW-1:DW] + {{(DW-1){1'b0}}, hi_cin};
    sum_o  = {hi_sum, lo_sum[DW-1:0]};
  end
endmodule

// File: rtl/smul_array16.sv
module smul_array16 #(
  parameter int LANE_W  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                split_i,
  input  logic [2*LANE_W-1:0] mcand_i,
  input  logic [2*LANE_W-1:0] mplier_i,
  output logic [4*LANE_W-1:0] prod_o
);
  localparam int DW = 2 * LANE_W;
  localparam int PW = 2 * DW;
  localparam int NU = DW / 2;
  localparam int NP = NU / 2;

  logic [DW-1:0] lo_path, hi_path;
  logic [PW-1:0] pp [NU];
  logic [PW-1:0] l1 [NP];
  logic [PW-1:0] lo_grp, hi_grp, lo_grp_gated, arr_sum;

  smul_precond #(.LANE_W(LANE_W)) u_precond (
    .split_i   (split_i),
    .mcand_i   (mcand_i),
    .lo_path_o (lo_path),
    .hi_path_o (hi_path)
  );

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic [DW-1:0] mc_sel;
    if (u < NU / 2) begin : g_lo
      assign mc_sel = lo_path;
    end else begin : g_hi
      assign mc_sel = hi_path;
    end
    smul_ppu #(.DW(DW), .IDX(u)) u_ppu (
      .split_i (split_i),
      .mc_i    (mc_sel),
      .mbits_i (mplier_i[2*u+1 -: 2]),
      .pp_o    (pp[u])
    );
  end

  for (genvar p = 0; p < NP; p++) begin : g_l1
    smul_padd #(.DW(DW)) u_padd (
      .split_i (split_i),
      .a_i     (pp[2*p]),
      .b_i     (pp[2*p+1]),
      .sum_o   (l1[p])
    );
  end

  // fixed-width levels; low-lane group gated at the boundary in split mode
  always_comb begin
    lo_grp = '0;
    hi_grp = '0;
    for (int i = 0; i < NP / 2; i++) begin
      lo_grp = lo_grp + l1[i];
      hi_grp = hi_grp + l1[NP/2 + i];
    end
    lo_grp_gated = split_i ? {{DW{1'b0}}, lo_grp[DW-1:0]} : lo_grp;
    arr_sum      = lo_grp_gated + hi_grp;
  end

  // independent reference values used by the checks below
  logic [PW-1:0] wide_ref, full_ref;
  logic [DW-1:0] lo_ref, hi_ref;
  always_comb begin
    wide_ref = $signed({{DW{mcand_i[DW-1]}}, mcand_i}) * $signed({{DW{1'b0}}, mplier_i});
    lo_ref   = $signed({{LANE_W{mcand_i[LANE_W-1]}}, mcand_i[LANE_W-1:0]})
             * $signed({{LANE_W{1'b0}}, mplier_i[LANE_W-1:0]});
    hi_ref   = $signed({{LANE_W{mcand_i[DW-1]}}, mcand_i[DW-1:LANE_W]})
             * $signed({{LANE_W{1'b0}}, mplier_i[DW-1:LANE_W]});
    full_ref = split_i ? {hi_ref, lo_ref} : wide_ref;
  end

  if (OUT_REG) begin : g_oreg
    logic [PW-1:0] prod_d, prod_q;
    logic          primed_q;

    always_comb prod_d = arr_sum;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q   <= '0;
        primed_q <= 1'b0;
      end else begin
        prod_q   <= prod_d;
        primed_q <= 1'b1;
      end
    end
    assign prod_o = prod_q;

    // R5
    out_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed_q |-> prod_o == $past(full_ref));

    // R6
    always @(posedge clk) begin
      if (!rst_n) begin
        rst_clr_chk: assert (prod_o == '0);
      end
    end
  end else begin : g_comb
    assign prod_o = arr_sum;
  end

  // R1
  wide_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !split_i |-> arr_sum == wide_ref);

  // R2
  lo_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_i |-> arr_sum[DW-1:0] == lo_ref);

  // R3
  hi_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_i |-> arr_sum[PW-1:DW] == hi_ref);

  for (genvar u = 0; u < NU / 2; u++) begin : g_iso
    // R4
    unit_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      split_i |-> pp[u][PW-1:DW] == '0 && pp[NU/2 + u][DW-1:0] == '0);
  end

  for (genvar p = 0; p < NP; p++) begin : g_l1iso
    // R4
    l1_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      split_i |-> l1[p][PW-1:DW] == pp[2*p][PW-1:DW] + pp[2*p+1][PW-1:DW]);
  end
endmodule

// File: tb/tb_smul_array16.sv
module tb_smul_array16;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        split_i;
  logic [15:0] mcand_i, mplier_i;
  logic [31:0] prod_o;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  bit       armed = 1'b0;

  smul_array16 dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .split_i  (split_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .prod_o   (prod_o)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b, input logic s);
    int pa, pb, la, lb, ha, hb;
    if (!s) begin
      pa = int'($signed(a));
      pb = int'(b);
      return 32'(pa * pb);
    end
    la = int'($signed(a[7:0]));
    lb = int'(b[7:0]);
    ha = int'($signed(a[15:8]));
    hb = int'(b[15:8]);
    return {16'(ha * hb), 16'(la * lb)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic s, input string tag);
    sb_item_t it;
    @(negedge clk);
    mcand_i  = a;
    mplier_i = b;
    split_i  = s;
    it.exp = model(a, b, s);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  // monitor: the item pushed before a rising edge is compared at the next falling edge
  always @(posedge clk) armed <= rst_n && (sb_q.size() > 0);

  always @(negedge clk) begin
    if (armed && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      check(it.tag, prod_o, it.exp);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; split_i = 1'b0; mcand_i = 16'h1234; mplier_i = 16'h5678;
    #5;
    check("R6 reset", prod_o, 32'h0);
    repeat (3) @(negedge clk);
    check("R6 held", prod_o, 32'h0);
    rst_n = 1'b1;

    // R1 corners
    drive(16'h8000, 16'hFFFF, 1'b0, "R1");
    drive(16'h7FFF, 16'hFFFF, 1'b0, "R1");
    drive(16'hFFFF, 16'h0001, 1'b0, "R1");
    drive(16'h0000, 16'hABCD, 1'b0, "R1");
    drive(16'h1234, 16'h5678, 1'b0, "R1");
    drive(16'hFF80, 16'h8000, 1'b0, "R1");
    // R2 R3 corners
    drive(16'h8080, 16'hFFFF, 1'b1, "R2 R3");
    drive(16'h7F7F, 16'hFFFF, 1'b1, "R2 R3");
    drive(16'hFF01, 16'h02FF, 1'b1, "R2 R3");
    drive(16'h0000, 16'hFFFF, 1'b1, "R2 R3");
    // R4 cross-lane: sign and carry pressure at the lane boundary
    drive(16'h80FF, 16'hFFFF, 1'b1, "R4");
    drive(16'h7F80, 16'h00FF, 1'b1, "R4");
    drive(16'h0080, 16'hFF00, 1'b1, "R4");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R4");
    drain();

    for (int i = 0; i < 150; i++)
      drive(16'($urandom), 16'($urandom), 1'b0, "R1");
    for (int i = 0; i < 150; i++)
      drive(16'($urandom), 16'($urandom), 1'b1, "R2 R3");
    // R5 back to back with alternating mode
    for (int i = 0; i < 100; i++)
      drive(16'($urandom), 16'($urandom), 1'(i % 2), "R5");
    drain();

    // R6 asynchronous reset mid-run
    drive(16'h1234, 16'h0101, 1'b0, "R1");
    drain();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R6 async", prod_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(16'h8001, 16'h0302, 1'b1, "R5");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule